// File: doc/BRIEF.md
# Partitioned Multi-FIFO with Prefetch Output

This block carves one shared memory into several independent logical FIFOs. Every FIFO owns a fixed, equal-size region and keeps its own wrap-around read and write pointers inside it. All FIFOs share a single write port: a write strobe comes with a FIFO index. The one memory read port is handed round-robin to the FIFOs that need a refill. Words that nobody has written to memory yet never mix between FIFOs.

Each FIFO has its own read side, built around a one-word output buffer. The buffer shows the head word before it is taken, so the read strobe works as an acknowledge. The empty flag is the inverse of the buffer's valid bit. It can therefore stay high for a short time while words still wait in memory for the shared read port.

Each read side also reports a registered fill level and a full flag. Both trail the stored count by one cycle. A single clock drives the whole block.

Top module: `part_fifo`

## Requirements
- R1: Each FIFO returns its accepted words in the order they were written, independently of traffic on the other FIFOs. FIFO n stores its words at memory addresses n*DEPTH to n*DEPTH+DEPTH-1.
- R2: A write happens when `wr_en` is high at a clock edge. `wr_sel` (binary index) picks the FIFO. The write is accepted only if that FIFO's stored count before the edge is below DEPTH. Otherwise it is dropped and has no effect.
- R3: Some writes go straight into the output buffer. This applies when the target FIFO has no words in memory, no fetch in flight, and an output buffer that is either empty or being acknowledged at the same edge. For such a write, `rd_empty` is low and `rd_data` shows the word at the first sample after the edge.
- R4: An `rd_ack` at an edge where that FIFO's `rd_empty` is high is ignored. No word is removed and the level is unaffected.
- R5: Acknowledge mode works as follows. While `rd_empty[n]` is low, `rd_data[n]` holds the oldest stored word of FIFO n. An `rd_ack[n]` at such an edge removes that word. `rd_empty[n]` is high whenever FIFO n stores nothing.
- R6: `rd_level[n]` equals the number of words FIFO n stored after the previous clock edge (one cycle of latency). This count includes the word in the output buffer, and it never exceeds DEPTH.
- R7: `rd_full[n]` is high exactly when FIFO n's stored count after the previous edge was DEPTH.
- R8: At most one memory read is issued per cycle. It is granted round-robin among the requesting FIFOs, with FIFO 0 first after reset. A FIFO requests when it has words in memory, no fetch in flight, and an output buffer that is empty or being acknowledged.
- R9: While FIFO n stores at least one word, `rd_empty[n]` stays high for at most NUM_Q consecutive cycles. When two FIFOs with backlog are both acknowledged at one edge, one of them shows data again after one cycle and the other after two.
- R10: After reset every FIFO reads empty, not full, with level 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | SW | Index of the FIFO to write |
| wr_data | input | DW | Write word |
| rd_ack | input | NUM_Q | Per-FIFO acknowledge of the head word |
| rd_data | output | NUM_Q*DW | Per-FIFO head word, FIFO n at bits n*DW |
| rd_empty | output | NUM_Q | Per-FIFO empty, inverse of head valid |
| rd_full | output | NUM_Q | Per-FIFO full, one cycle late |
| rd_level | output | NUM_Q*LW | Per-FIFO stored count, one cycle late, FIFO n at bits n*LW |

## Verification
Two FIFOs can need the shared memory read port in the same cycle. When that happens, one refill must wait while the other is served. The bench fills both FIFOs with a backlog, lets the buffers settle, and then acknowledges both heads at the same edge. It counts how many samples each `rd_empty` stays high, and expects one FIFO to be empty for one sample and the other for two. The random phase creates the same collision many times. There, a streak counter per FIFO checks the NUM_Q bound, and the per-FIFO queue models check that the delayed refill still delivers the right word.

// File: rtl/part_fifo_pkg.sv
package part_fifo_pkg;

  // Memory word index of slot `ptr` inside the region of FIFO `q`.
  function automatic int unsigned slot_addr(int unsigned q, int unsigned ptr,
                                            int unsigned depth);
    return q * depth + ptr;
  endfunction

  // Stored-count update for one edge: one possible push, one possible pop.
  function automatic int unsigned count_step(int unsigned cnt, bit push, bit pop);
    return cnt + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

endpackage

// File: rtl/part_fifo_arb.sv
module part_fifo_arb #(
  parameter int NUM_Q = 2,
  localparam int IW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_Q-1:0] req,
  output logic [NUM_Q-1:0] gnt,
  output logic [IW-1:0]    gnt_idx
);

  logic [IW-1:0] last_q;

  always_comb begin
    logic hit;
    int   idx;
    hit     = 1'b0;
    gnt     = '0;
    gnt_idx = '0;
    for (int k = 1; k <= NUM_Q; k++) begin
      idx = (int'(last_q) + k) % NUM_Q;
      if (!hit && req[idx]) begin
        hit          = 1'b1;
        gnt[idx]     = 1'b1;
        gnt_idx      = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    last_q <= IW'(NUM_Q - 1);
    else if (|gnt) last_q <= gnt_idx;
  end

  // R8: one grant per cycle, only to a requester
  a_r8_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  a_r8_grant_has_req: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
  // R8: the last winner loses to another requester next time
  a_r8_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt) && $countones(req) > 1) |-> gnt_idx != last_q);

endmodule

// File: rtl/part_fifo_lane.sv
module part_fifo_lane #(
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic [DW-1:0] wr_data,
  input  logic          ack,
  input  logic          gnt,
  input  logic [DW-1:0] land_data,
  output logic          req,
  output logic          to_mem,
  output logic [AW-1:0] rptr,
  output logic [AW-1:0] wptr,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          full,
  output logic [LW-1:0] level
);
  import part_fifo_pkg::*;

  logic [LW-1:0] total_q, mem_cnt_q, level_q;
  logic [AW-1:0] rptr_q, wptr_q;
  logic [DW-1:0] buf_q;
  logic          buf_valid_q, inflight_q, full_q;

  // named internal events
  logic ack_ok, wr_ok, buf_free, bypass;
  assign ack_ok   = ack && buf_valid_q;
  assign wr_ok    = wr_hit && (total_q < LW'(DEPTH));
  assign buf_free = !buf_valid_q || ack_ok;
  assign bypass   = wr_ok && (mem_cnt_q == '0) && !inflight_q && buf_free;
  assign to_mem   = wr_ok && !bypass;
  assign req      = (mem_cnt_q != '0) && !inflight_q && buf_free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      total_q     <= '0;
      mem_cnt_q   <= '0;
      rptr_q      <= '0;
      wptr_q      <= '0;
      buf_valid_q <= 1'b0;
      inflight_q  <= 1'b0;
      level_q     <= '0;
      full_q      <= 1'b0;
    end else begin
      total_q    <= LW'(count_step(32'(total_q), wr_ok, ack_ok));
      mem_cnt_q  <= LW'(count_step(32'(mem_cnt_q), to_mem, gnt));
      inflight_q <= gnt;
      if (gnt)    rptr_q <= rptr_q + 1'b1;
      if (to_mem) wptr_q <= wptr_q + 1'b1;
      if (bypass || inflight_q) buf_valid_q <= 1'b1;
      else if (ack_ok)          buf_valid_q <= 1'b0;
      level_q <= total_q;
      full_q  <= (total_q == LW'(DEPTH));
    end
  end

  always_ff @(posedge clk) begin
    if (bypass)          buf_q <= wr_data;
    else if (inflight_q) buf_q <= land_data;
  end

  assign rptr  = rptr_q;
  assign wptr  = wptr_q;
  assign head  = buf_q;
  assign empty = !buf_valid_q;
  assign full  = full_q;
  assign level = level_q;

  // R4: an acknowledge on an empty buffer removes nothing
  a_r4_ack_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !buf_valid_q && !wr_hit) |=> total_q == $past(total_q));
  // R2: a write into a full FIFO leaves it full
  a_r2_drop_full: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && total_q == LW'(DEPTH) && !ack) |=> total_q == LW'(DEPTH));
  // R3: a write into an idle FIFO is visible right after the edge
  a_r3_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && total_q == '0) |=> buf_valid_q);
  // R5: the head word holds until acknowledged
  a_r5_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_valid_q && !ack) |=> (buf_valid_q && $stable(buf_q)));
  // R6: level bounded by the region depth
  a_r6_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LW'(DEPTH));
  // R9: never a fetched word and a held word at once
  a_r9_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !(inflight_q && buf_valid_q));
  // R8: the arbiter serves only a requesting lane
  a_r8_gnt_req: assert property (@(posedge clk) disable iff (!rst_n)
    gnt |-> req);

endmodule

// File: rtl/part_fifo.sv
module part_fifo #(
  parameter int NUM_Q = 2,
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  localparam int SW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int MW = $clog2(NUM_Q * DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SW-1:0]       wr_sel,
  input  logic [DW-1:0]       wr_data,
  input  logic [NUM_Q-1:0]    rd_ack,
  output logic [NUM_Q*DW-1:0] rd_data,
  output logic [NUM_Q-1:0]    rd_empty,
  output logic [NUM_Q-1:0]    rd_full,
  output logic [NUM_Q*LW-1:0] rd_level
);
  import part_fifo_pkg::*;

  logic [NUM_Q-1:0] req, gnt, to_mem;
  logic [SW-1:0]    gnt_idx;
  logic [AW-1:0]    rptr [NUM_Q];
  logic [AW-1:0]    wptr [NUM_Q];
  logic [DW-1:0]    mem  [NUM_Q*DEPTH];
  logic [DW-1:0]    land_q;
  logic [MW-1:0]    wr_addr, rd_addr;

  generate
    for (genvar g = 0; g < NUM_Q; g++) begin : g_lane
      part_fifo_lane #(.DEPTH(DEPTH), .DW(DW)) u_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (wr_en && (wr_sel == SW'(g))),
        .wr_data  (wr_data),
        .ack      (rd_ack[g]),
        .gnt      (gnt[g]),
        .land_data(land_q),
        .req      (req[g]),
        .to_mem   (to_mem[g]),
        .rptr     (rptr[g]),
        .wptr     (wptr[g]),
        .head     (rd_data[g*DW +: DW]),
        .empty    (rd_empty[g]),
        .full     (rd_full[g]),
        .level    (rd_level[g*LW +: LW])
      );
    end
  endgenerate

  part_fifo_arb #(.NUM_Q(NUM_Q)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req),
    .gnt    (gnt),
    .gnt_idx(gnt_idx)
  );

  assign wr_addr = MW'(slot_addr(32'(wr_sel),  32'(wptr[wr_sel]),  DEPTH));
  assign rd_addr = MW'(slot_addr(32'(gnt_idx), 32'(rptr[gnt_idx]), DEPTH));

  always_ff @(posedge clk) begin
    if (|to_mem) mem[wr_addr] <= wr_data;
    if (|gnt)    land_q       <= mem[rd_addr];
  end

  // R2: one shared write port, only the selected lane may store
  a_r2_one_store: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(to_mem));
  a_r2_store_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (|to_mem) |-> (wr_en && to_mem[wr_sel]));
  // R1: the write and the fetch never hit the same word
  a_r1_no_clash: assert property (@(posedge clk) disable iff (!rst_n)
    ((|to_mem) && (|gnt)) |-> wr_addr != rd_addr);

endmodule

// File: tb/test_part_fifo.sv
module test_part_fifo;
  localparam int NQ = 2;
  localparam int DP = 4;
  localparam int DW = 8;
  localparam int LW = $clog2(DP + 1);

  // stimulus rows: {wr_en, wr_sel, wr_data[7:0], rd_ack[1:0]}
  localparam logic [11:0] STIM [16] = '{
    {1'b1, 1'b0, 8'h11, 2'b00}, {1'b1, 1'b1, 8'h21, 2'b00},
    {1'b1, 1'b0, 8'h12, 2'b00}, {1'b1, 1'b0, 8'h13, 2'b00},
    {1'b1, 1'b1, 8'h22, 2'b00}, {1'b0, 1'b0, 8'h00, 2'b01},
    {1'b1, 1'b0, 8'h14, 2'b10}, {1'b1, 1'b0, 8'h15, 2'b00},
    {1'b1, 1'b0, 8'h16, 2'b00}, {1'b1, 1'b1, 8'h23, 2'b11},
    {1'b0, 1'b0, 8'h00, 2'b11}, {1'b1, 1'b1, 8'h24, 2'b11},
    {1'b0, 1'b0, 8'h00, 2'b11}, {1'b1, 1'b0, 8'h17, 2'b01},
    {1'b0, 1'b0, 8'h00, 2'b11}, {1'b0, 1'b0, 8'h00, 2'b11}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic            wr_sel = 1'b0;
  logic [DW-1:0]   wr_data = '0;
  logic [NQ-1:0]   rd_ack = '0;
  logic [NQ*DW-1:0] rd_data;
  logic [NQ-1:0]   rd_empty, rd_full;
  logic [NQ*LW-1:0] rd_level;

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] mq [NQ][$];
  int prev_total [NQ];
  int streak [NQ];
  logic [NQ-1:0] samp_empty = '1;
  logic [15:0] lf = 16'hACE1;

  always #4 clk = ~clk;

  part_fifo #(.NUM_Q(NQ), .DEPTH(DP), .DW(DW)) i_part_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_ack(rd_ack), .rd_data(rd_data),
    .rd_empty(rd_empty), .rd_full(rd_full), .rd_level(rd_level)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: model update at the edge, output checks at the falling edge
  task automatic tick();
    @(posedge clk);
    for (int n = 0; n < NQ; n++) prev_total[n] = mq[n].size();
    if (rst_n) begin
      if (wr_en && mq[wr_sel].size() < DP) mq[wr_sel].push_back(wr_data); // R2
      for (int n = 0; n < NQ; n++)
        if (rd_ack[n] && !samp_empty[n]) void'(mq[n].pop_front());       // R4, R5
    end
    @(negedge clk);
    samp_empty = rd_empty;
    for (int n = 0; n < NQ; n++) begin
      chk(rd_level[n*LW +: LW] == LW'(prev_total[n]), "R6 level",
          int'(rd_level[n*LW +: LW]), prev_total[n]);
      chk(rd_full[n] == (prev_total[n] == DP), "R7 full",
          int'(rd_full[n]), int'(prev_total[n] == DP));
      if (mq[n].size() == 0)
        chk(rd_empty[n] == 1'b1, "R5 empty when nothing stored", int'(rd_empty[n]), 1);
      if (rd_empty[n] && mq[n].size() > 0) streak[n]++;
      else streak[n] = 0;
      chk(streak[n] <= NQ, "R9 empty window", streak[n], NQ);
    end
  endtask

  task automatic drive(bit we, bit sel, logic [DW-1:0] d, logic [NQ-1:0] ack);
    wr_en = we; wr_sel = sel; wr_data = d; rd_ack = ack;
    for (int n = 0; n < NQ; n++)
      if (ack[n] && !samp_empty[n] && mq[n].size() > 0)
        chk(rd_data[n*DW +: DW] == mq[n][0], "R1 R5 head order",
            int'(rd_data[n*DW +: DW]), int'(mq[n][0]));
    tick();
  endtask

  task automatic drain();
    for (int c = 0; c < 60; c++) begin
      if (mq[0].size() == 0 && mq[1].size() == 0 && samp_empty == '1) break;
      drive(1'b0, 1'b0, '0, ~samp_empty);
    end
    drive(1'b0, 1'b0, '0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int ecnt [NQ];
    for (int n = 0; n < NQ; n++) begin prev_total[n] = 0; streak[n] = 0; end
    // R10: reset state
    @(negedge clk);
    repeat (3) tick();
    chk(rd_empty == '1, "R10 empty", int'(rd_empty), 3);
    chk(rd_full == '0, "R10 full", int'(rd_full), 0);
    chk(rd_level == '0, "R10 level", int'(rd_level), 0);
    rst_n = 1'b1;
    tick();

    // stimulus table
    for (int i = 0; i < 16; i++)
      drive(STIM[i][11], STIM[i][10], STIM[i][9:2], STIM[i][1:0]);
    drain();

    // random traffic on both FIFOs
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      drive(lf[0] | lf[7], lf[3], lf[15:8], {lf[5] & lf[2], lf[6] | lf[1]});
    end
    drain();

    // R4: acknowledges while empty are ignored, then R3 direct write
    repeat (3) drive(1'b0, 1'b0, '0, 2'b11);
    chk(rd_level == '0, "R4 level after idle acks", int'(rd_level), 0);
    drive(1'b1, 1'b0, 8'hA5, 2'b00);
    chk(rd_empty[0] == 1'b0, "R3 empty after direct write", int'(rd_empty[0]), 0);
    chk(rd_data[7:0] == 8'hA5, "R3 head after direct write", int'(rd_data[7:0]), 'hA5);
    drain();

    // R2, R7: overfill FIFO 1, extra words dropped
    for (int i = 0; i < DP + 2; i++) drive(1'b1, 1'b1, 8'hC0 + 8'(i), 2'b00);
    drive(1'b0, 1'b0, '0, 2'b00);
    chk(rd_full[1] == 1'b1, "R7 full after overfill", int'(rd_full[1]), 1);
    chk(rd_level[LW +: LW] == LW'(DP), "R2 level capped", int'(rd_level[LW +: LW]), DP);
    chk(mq[1].size() == DP, "R2 model capped", mq[1].size(), DP);
    drain();

    // R9: both FIFOs drained at the same edge with backlog
    for (int i = 0; i < 3; i++) begin
      drive(1'b1, 1'b0, 8'h30 + 8'(i), 2'b00);
      drive(1'b1, 1'b1, 8'h40 + 8'(i), 2'b00);
    end
    repeat (3) drive(1'b0, 1'b0, '0, 2'b00);
    ecnt[0] = 0; ecnt[1] = 0;
    drive(1'b0, 1'b0, '0, 2'b11);
    for (int c = 0; c < 3; c++) begin
      for (int n = 0; n < NQ; n++) ecnt[n] += int'(samp_empty[n]);
      if (c < 2) drive(1'b0, 1'b0, '0, 2'b00);
    end
    chk((ecnt[0] + ecnt[1]) == 3, "R9 collision total wait", ecnt[0] + ecnt[1], 3);
    chk(((ecnt[0] == 1) || (ecnt[1] == 1)), "R8 R9 one side refilled first",
        ecnt[0] * 16 + ecnt[1], 'h12);
    drain();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule